// File: doc/BRIEF.md
# Debug Bus Access Match Comparator

This block is one hardware breakpoint comparator for an on-chip debug unit. On every bus strobe it checks the access against a programmed address. It can watch either instruction fetches, by program-counter address, or data accesses, by access address. In data mode the match can also depend on the access direction and on the data value, compared under a per-bit mask. A qualifying access gives a match pulse one cycle long, one clock after the strobe. The arming logic, the trace store and the breakpoint response use this pulse.

Software programs the comparator through a byte-wide register window. Reads are allowed at any time. Writes are accepted only while the debug unit is not armed and no trace is running. When either flag is set, writes are dropped without notice. Accesses from the narrow 16-bit bus master carry their data on the low half of the data bus. For these accesses only mask and compare-data bits 15:0 take part in the match.

Top module: `dbg_match_cmp`

## Requirements
- R1: After reset every register offset reads 0x00 and `match_o` is low.
- R2: When control bit 0 (enable) is 0, `match_o` never asserts.
- R3: When control bit 1 (fetch-select) is 1, a match needs an instruction fetch (`bus_is_fetch`=1) whose address equals the compare address. Data accesses never match in this mode, and the direction bits and the data are ignored.
- R4: When fetch-select is 0, a match needs a data access (`bus_is_fetch`=0) whose 24-bit address exactly equals the compare address. Fetches never match in this mode.
- R5: In data mode, control bit 2 (direction-enable) set to 0 leaves direction out of the match. When it is 1, `bus_read` must equal control bit 3, where 1 matches reads and 0 matches writes.
- R6: In data mode, every mask bit at 1 requires the bus data bit to equal the compare-data bit. Mask bits at 0 are excluded, so an all-zero mask gives an address-only match, or an address-and-direction match when direction is enabled.
- R7: The register window places control at offset 0 and the address at offsets 1..3, with bits 23:16 first. Compare data sits at offsets 4..7 and the mask at offsets 8..11, each with bits 31:24 first, down to bits 7:0 at the last offset.
- R8: For an access with `bus_narrow`=1, only data bits 15:0 are compared. Mask bits 31:16 then have no effect.
- R9: A write made while `dbg_armed` or `trace_active` is 1 changes no register. Reads return current contents at any time.
- R10: `match_o` is registered. It is high in the cycle after each qualifying strobe and for that cycle only, so back-to-back strobes give back-to-back pulses. A write in the same cycle as a strobe affects only later strobes.
- R11: Control bits 7:4 read as 0. Offsets 12..15 read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_armed | input | 1 | Debug unit armed; blocks configuration writes |
| trace_active | input | 1 | Trace running; blocks configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register offset |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Configuration read byte for `cfg_addr` |
| bus_valid | input | 1 | Bus access strobe |
| bus_is_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_read | input | 1 | 1 = read, 0 = write |
| bus_narrow | input | 1 | Access from the 16-bit master, data on bits 15:0 |
| bus_addr | input | 24 | Access address |
| bus_data | input | 32 | Access data |
| match_o | output | 1 | One-cycle match pulse |

## Verification
A configuration write and a bus strobe can land in the same clock. The match must then be judged against the settings in force before the write. The bench provokes this in two ways. It writes a disabling control byte in the same cycle as a matching strobe. Its random phase also mixes register writes with strobes on every cycle, some of them while locked. The behavioural model in the bench evaluates each strobe first and applies the write afterwards, then compares the pulse and the read-back byte on every clock.

// File: rtl/dbg_cmp_pkg.sv
package dbg_cmp_pkg;

   localparam int CTRL_W = 4;

   typedef struct packed {
      logic dir_read;
      logic dir_en;
      logic pc_sel;
      logic enable;
   } cmp_ctrl_t;

endpackage

// File: rtl/dbg_cmp_regs.sv
module dbg_cmp_regs
   import dbg_cmp_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 32,
   parameter int CFG_AW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata,
   input  logic              wr_lock,
   output cmp_ctrl_t         ctrl_q,
   output logic [ADDR_W-1:0] cmp_addr_q,
   output logic [DATA_W-1:0] cmp_data_q,
   output logic [DATA_W-1:0] cmp_mask_q,
   output logic [7:0]        cfg_rdata
);

   localparam int ABYTES   = ADDR_W / 8;
   localparam int DBYTES   = DATA_W / 8;
   localparam int OFS_ADDR = 1;
   localparam int OFS_DATA = OFS_ADDR + ABYTES;
   localparam int OFS_MASK = OFS_DATA + DBYTES;

   logic              wr_ok;
   logic              ctrl_sel;
   logic [ABYTES-1:0] addr_sel;
   logic [DBYTES-1:0] data_sel;
   logic [DBYTES-1:0] mask_sel;

   assign wr_ok    = cfg_we & ~wr_lock;
   assign ctrl_sel = (cfg_addr == '0);

   // lane decode: lane 0 of every field holds its most significant byte
   for (genvar g = 0; g < ABYTES; g++) begin : g_addr_dec
      assign addr_sel[g] = (cfg_addr == CFG_AW'(OFS_ADDR + g));
   end
   for (genvar g = 0; g < DBYTES; g++) begin : g_dm_dec
      assign data_sel[g] = (cfg_addr == CFG_AW'(OFS_DATA + g));
      assign mask_sel[g] = (cfg_addr == CFG_AW'(OFS_MASK + g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q     <= '0;
         cmp_addr_q <= '0;
         cmp_data_q <= '0;
         cmp_mask_q <= '0;
      end else if (wr_ok) begin
         if (ctrl_sel) ctrl_q <= cmp_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
         for (int i = 0; i < ABYTES; i++) begin
            if (addr_sel[i]) cmp_addr_q[(ABYTES-1-i)*8 +: 8] <= cfg_wdata;
         end
         for (int i = 0; i < DBYTES; i++) begin
            if (data_sel[i]) cmp_data_q[(DBYTES-1-i)*8 +: 8] <= cfg_wdata;
            if (mask_sel[i]) cmp_mask_q[(DBYTES-1-i)*8 +: 8] <= cfg_wdata;
         end
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (ctrl_sel) cfg_rdata = {{(8-CTRL_W){1'b0}}, ctrl_q};
      for (int i = 0; i < ABYTES; i++) begin
         if (addr_sel[i]) cfg_rdata = cmp_addr_q[(ABYTES-1-i)*8 +: 8];
      end
      for (int i = 0; i < DBYTES; i++) begin
         if (data_sel[i]) cfg_rdata = cmp_data_q[(DBYTES-1-i)*8 +: 8];
         if (mask_sel[i]) cfg_rdata = cmp_mask_q[(DBYTES-1-i)*8 +: 8];
      end
   end

endmodule

// File: rtl/dbg_cmp_data.sv
module dbg_cmp_data #(
   parameter int DATA_W   = 32,
   parameter int NARROW_W = 16
) (
   input  logic [DATA_W-1:0] bus_data,
   input  logic [DATA_W-1:0] cmp_data,
   input  logic [DATA_W-1:0] cmp_mask,
   input  logic              narrow,
   output logic              data_hit
);

   localparam int LANES = DATA_W / 8;

   logic [LANES-1:0] lane_ok;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] diff;
      assign diff = (bus_data[g*8 +: 8] ^ cmp_data[g*8 +: 8]) & cmp_mask[g*8 +: 8];
      if (g * 8 >= NARROW_W) begin : g_wide_only
         // lanes above the narrow master's width drop out for its accesses
         assign lane_ok[g] = narrow | (diff == 8'h00);
      end else begin : g_shared
         assign lane_ok[g] = (diff == 8'h00);
      end
   end

   assign data_hit = &lane_ok;

endmodule

// File: rtl/dbg_cmp_core.sv
module dbg_cmp_core
   import dbg_cmp_pkg::*;
#(
   parameter int ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cmp_ctrl_t         ctrl,
   input  logic [ADDR_W-1:0] cmp_addr,
   input  logic              bus_valid,
   input  logic              bus_is_fetch,
   input  logic              bus_read,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              data_hit,
   output logic              match_o
);

   logic addr_eq;
   logic dir_ok;
   logic kind_ok;
   logic hit_d;

   always_comb begin
      addr_eq = (bus_addr == cmp_addr);
      dir_ok  = ~ctrl.dir_en | (bus_read == ctrl.dir_read);
      if (ctrl.pc_sel) kind_ok = bus_is_fetch;
      else             kind_ok = ~bus_is_fetch & dir_ok & data_hit;
      hit_d   = bus_valid & ctrl.enable & addr_eq & kind_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_o <= 1'b0;
      else        match_o <= hit_d;
   end

endmodule

// File: rtl/dbg_match_cmp.sv
module dbg_match_cmp
   import dbg_cmp_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int DATA_W   = 32,
   parameter int NARROW_W = 16,
   parameter int CFG_AW   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbg_armed,
   input  logic              trace_active,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic              bus_valid,
   input  logic              bus_is_fetch,
   input  logic              bus_read,
   input  logic              bus_narrow,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   output logic              match_o
);

   localparam int NREGS = 1 + ADDR_W / 8 + 2 * (DATA_W / 8);

   if (ADDR_W < 8 || ADDR_W % 8 != 0) begin : g_bad_addr_w
      $error("ADDR_W must be a nonzero multiple of 8");
   end
   if (DATA_W < 8 || DATA_W % 8 != 0) begin : g_bad_data_w
      $error("DATA_W must be a nonzero multiple of 8");
   end
   if (NARROW_W < 8 || NARROW_W % 8 != 0 || NARROW_W > DATA_W) begin : g_bad_narrow_w
      $error("NARROW_W must be a multiple of 8 no wider than DATA_W");
   end
   if ((1 << CFG_AW) < NREGS) begin : g_bad_cfg_aw
      $error("CFG_AW too small for the register window");
   end

   cmp_ctrl_t         ctrl_q;
   logic [ADDR_W-1:0] cmp_addr_q;
   logic [DATA_W-1:0] cmp_data_q;
   logic [DATA_W-1:0] cmp_mask_q;
   logic              data_hit;
   logic              wr_lock;

   assign wr_lock = dbg_armed | trace_active;

   dbg_cmp_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CFG_AW (CFG_AW)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .wr_lock    (wr_lock),
      .ctrl_q     (ctrl_q),
      .cmp_addr_q (cmp_addr_q),
      .cmp_data_q (cmp_data_q),
      .cmp_mask_q (cmp_mask_q),
      .cfg_rdata  (cfg_rdata)
   );

   dbg_cmp_data #(
      .DATA_W   (DATA_W),
      .NARROW_W (NARROW_W)
   ) u_data (
      .bus_data (bus_data),
      .cmp_data (cmp_data_q),
      .cmp_mask (cmp_mask_q),
      .narrow   (bus_narrow),
      .data_hit (data_hit)
   );

   dbg_cmp_core #(
      .ADDR_W (ADDR_W)
   ) u_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctrl         (ctrl_q),
      .cmp_addr     (cmp_addr_q),
      .bus_valid    (bus_valid),
      .bus_is_fetch (bus_is_fetch),
      .bus_read     (bus_read),
      .bus_addr     (bus_addr),
      .data_hit     (data_hit),
      .match_o      (match_o)
   );

endmodule

// File: rtl/dbg_match_cmp_chk.sv
module dbg_match_cmp_chk
   import dbg_cmp_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int CFG_AW = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dbg_armed,
   input logic              trace_active,
   input logic              cfg_we,
   input logic [CFG_AW-1:0] cfg_addr,
   input logic [7:0]        cfg_rdata,
   input logic              bus_valid,
   input logic              bus_is_fetch,
   input logic              bus_read,
   input logic [ADDR_W-1:0] bus_addr,
   input cmp_ctrl_t         ctrl_q,
   input logic [ADDR_W-1:0] cmp_addr_q,
   input logic              match_o
);

   AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |=> !match_o); // R10

   AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.enable |=> !match_o); // R2

   AST_FETCH_MODE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && ctrl_q.pc_sel && !bus_is_fetch) |=> !match_o); // R3

   AST_DATA_MODE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !ctrl_q.pc_sel && bus_is_fetch) |=> !match_o); // R4

   AST_ADDR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && (bus_addr != cmp_addr_q)) |=> !match_o); // R4

   AST_DIR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !ctrl_q.pc_sel && ctrl_q.dir_en && (bus_read != ctrl_q.dir_read))
      |=> !match_o); // R5

   AST_LOCKED_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (dbg_armed || trace_active)) |=> ($stable(ctrl_q) && $stable(cmp_addr_q))); // R9

   AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr == '0) |-> (cfg_rdata[7:4] == 4'h0)); // R11

endmodule

bind dbg_match_cmp dbg_match_cmp_chk #(
   .ADDR_W (ADDR_W),
   .CFG_AW (CFG_AW)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .dbg_armed    (dbg_armed),
   .trace_active (trace_active),
   .cfg_we       (cfg_we),
   .cfg_addr     (cfg_addr),
   .cfg_rdata    (cfg_rdata),
   .bus_valid    (bus_valid),
   .bus_is_fetch (bus_is_fetch),
   .bus_read     (bus_read),
   .bus_addr     (bus_addr),
   .ctrl_q       (ctrl_q),
   .cmp_addr_q   (cmp_addr_q),
   .match_o      (match_o)
);

// File: tb/test_dbg_match_cmp.sv
`timescale 1ns/1ps
module test_dbg_match_cmp;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dbg_armed = 1'b0;
   logic        trace_active = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic        bus_valid = 1'b0;
   logic        bus_is_fetch = 1'b0;
   logic        bus_read = 1'b0;
   logic        bus_narrow = 1'b0;
   logic [23:0] bus_addr = '0;
   logic [31:0] bus_data = '0;
   logic        match_o;

   int    vectors = 0;
   int    fails = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   bit [7:0] mr [16];
   bit       exp_match = 1'b0;

   always #2.5 clk = ~clk;

   dbg_match_cmp i_dbg_match_cmp (
      .clk (clk), .rst_n (rst_n), .dbg_armed (dbg_armed), .trace_active (trace_active),
      .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
      .bus_valid (bus_valid), .bus_is_fetch (bus_is_fetch), .bus_read (bus_read),
      .bus_narrow (bus_narrow), .bus_addr (bus_addr), .bus_data (bus_data), .match_o (match_o)
   );

   function automatic bit [7:0] model_read(int a);
      if (a < 12) return mr[a];
      return 8'h00;
   endfunction

   function automatic bit model_hit();
      bit [23:0] ca;
      bit [31:0] cd, cm, diff;
      ca = {mr[1], mr[2], mr[3]};
      cd = {mr[4], mr[5], mr[6], mr[7]};
      cm = {mr[8], mr[9], mr[10], mr[11]};
      if (!bus_valid || !mr[0][0]) return 1'b0;
      if (bus_addr != ca) return 1'b0;
      if (mr[0][1]) return bus_is_fetch;
      if (bus_is_fetch) return 1'b0;
      if (mr[0][2] && (bus_read != mr[0][3])) return 1'b0;
      diff = (bus_data ^ cd) & cm;
      if (bus_narrow) diff = diff & 32'h0000_FFFF;
      return diff == 32'h0;
   endfunction

   // reference model: judge the strobe with old settings, then apply the write
   always @(posedge clk) begin
      if (!rst_n) begin
         exp_match <= 1'b0;
         for (int i = 0; i < 16; i++) mr[i] = 8'h00;
      end else begin
         exp_match <= model_hit();
         if (cfg_we && !dbg_armed && !trace_active && cfg_addr < 12)
            mr[cfg_addr] = (cfg_addr == 0) ? (cfg_wdata & 8'h0F) : cfg_wdata;
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         vectors++;
         if (match_o !== exp_match) begin
            fails++;
            $display("FAIL %s match_o=%0b expected %0b (t=%0t)", cur_req, match_o, exp_match, $time);
         end
         if (cfg_rdata !== model_read(int'(cfg_addr))) begin
            fails++;
            $display("FAIL %s cfg_rdata[%0d]=%02h expected %02h", cur_req, cfg_addr, cfg_rdata,
                     model_read(int'(cfg_addr)));
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input int a, input bit [7:0] d);
      cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
      step();
      cfg_we = 1'b0;
   endtask

   task automatic rd(input int a);
      cfg_addr = 4'(a);
      step();
   endtask

   task automatic acc(input bit f, input bit [23:0] a, input bit r, input bit n, input bit [31:0] d);
      bus_valid = 1'b1; bus_is_fetch = f; bus_addr = a; bus_read = r; bus_narrow = n; bus_data = d;
      step();
      bus_valid = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog expired in phase %s", cur_req);
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      // R1: reset contents, swept while reset is held
      cur_req = "R1";
      for (int i = 0; i < 16; i++) rd(i);
      rst_n = 1'b1;
      step();

      cur_req = "R11";
      wr(0, 8'hFF); rd(0); rd(12); rd(15);

      cur_req = "R7";
      wr(1, 8'h12); wr(2, 8'h34); wr(3, 8'h56);
      wr(4, 8'hAB); wr(5, 8'h00); wr(6, 8'hCD); wr(7, 8'h00);
      for (int i = 1; i < 12; i++) rd(i);

      cur_req = "R3";
      wr(0, 8'h0F);
      acc(1, 24'h123456, 0, 0, 32'hDEAD_BEEF); step();
      acc(0, 24'h123456, 1, 0, 32'hAB00_CD00); step();
      acc(1, 24'h123457, 1, 0, 32'h0);         step();

      cur_req = "R2";
      wr(0, 8'h0E); acc(1, 24'h123456, 0, 0, 32'h0); step();
      wr(0, 8'h0C); acc(0, 24'h123456, 1, 0, 32'hAB00_CD00); step();

      cur_req = "R4";
      wr(0, 8'h01);
      acc(0, 24'h123456, 1, 0, 32'h5555_5555); step();
      acc(1, 24'h123456, 1, 0, 32'h0);         step();
      acc(0, 24'h023456, 1, 0, 32'h0);         step();

      cur_req = "R6";
      wr(8, 8'hFF); wr(9, 8'h00); wr(10, 8'hFF); wr(11, 8'h00);
      acc(0, 24'h123456, 0, 0, 32'hAB11_CD22); step();
      acc(0, 24'h123456, 0, 0, 32'h2B11_CD22); step();
      acc(0, 24'h123456, 0, 0, 32'hAB11_CC22); step();

      cur_req = "R8";
      wr(4, 8'h12); wr(5, 8'h34); wr(6, 8'h00); wr(7, 8'h56);
      wr(8, 8'hFF); wr(9, 8'hFF); wr(10, 8'h00); wr(11, 8'hFF);
      acc(0, 24'h123456, 1, 1, 32'h0000_7756); step();
      acc(0, 24'h123456, 1, 0, 32'h0000_7756); step();
      acc(0, 24'h123456, 1, 1, 32'h0000_7757); step();

      cur_req = "R5";
      for (int i = 8; i < 12; i++) wr(i, 8'h00);
      wr(0, 8'h05);
      acc(0, 24'h123456, 1, 0, 32'h0); step();
      acc(0, 24'h123456, 0, 0, 32'h0); step();
      wr(0, 8'h0D);
      acc(0, 24'h123456, 1, 0, 32'h0); step();
      acc(0, 24'h123456, 0, 0, 32'h0); step();
      wr(0, 8'h09);
      acc(0, 24'h123456, 0, 0, 32'h0); step();

      cur_req = "R9";
      dbg_armed = 1'b1;
      wr(0, 8'h00); rd(0);
      acc(0, 24'h123456, 1, 0, 32'h0); step();
      dbg_armed = 1'b0; trace_active = 1'b1;
      wr(1, 8'hFF); rd(1);
      acc(0, 24'h123456, 1, 0, 32'h0); step();
      trace_active = 1'b0;

      cur_req = "R10";
      acc(0, 24'h123456, 1, 0, 32'h1);
      acc(0, 24'h123456, 0, 0, 32'h2);
      acc(0, 24'h123456, 1, 0, 32'h3);
      step(); step();
      // write landing with a matching strobe: that strobe still matches
      cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 8'h00;
      acc(0, 24'h123456, 1, 0, 32'h0);
      cfg_we = 1'b0;
      acc(0, 24'h123456, 1, 0, 32'h0);
      step();

      cur_req = "R10";
      for (int n = 0; n < 600; n++) begin
         int unsigned r;
         r = $urandom;
         dbg_armed    = (r[3:0] == 4'h0);
         trace_active = (r[7:4] == 4'h0);
         cfg_we       = r[8] & r[9];
         cfg_addr     = 4'($urandom_range(0, 15));
         cfg_wdata    = (r[10] && cfg_addr >= 8) ? 8'h00 : 8'($urandom);
         bus_valid    = r[11] | r[12];
         bus_is_fetch = r[13];
         bus_read     = r[14];
         bus_narrow   = r[15];
         bus_addr     = r[16] ? {mr[1], mr[2], mr[3]} : 24'($urandom);
         bus_data     = r[17] ? {mr[4], mr[5], mr[6], mr[7]} ^ 32'(r[18]) : $urandom;
         step();
      end
      cfg_we = 1'b0; bus_valid = 1'b0; dbg_armed = 1'b0; trace_active = 1'b0;
      step(); step();

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule